// File: doc/BRIEF.md
# Upper Memory Shadow Decoder

This block steers every CPU memory access that falls in the upper 384 KiB below 1 MiB. The span from C0000h to FFFFFh is split into thirteen shadow segments. Segments 0 to 11 are 16 KiB each and cover C0000h–EFFFFh, and segment 12 is the 64 KiB system firmware area F0000h–FFFFFh. Each segment has two independent controls. One chooses whether reads are served by the ROM device or by the DRAM copy at the same address. The other chooses whether writes reach that DRAM copy or are discarded. With reads on ROM and writes on DRAM, firmware can copy a ROM image onto itself. Clearing the write control afterwards makes the copy read-only.

The video hole A0000h–BFFFFh is always passed to the expansion bus. A relocation switch can expose the DRAM hidden behind A0000h–FFFFFh as a 384 KiB window that starts at the installed-memory top. Window chunks whose hidden DRAM is already used by a shadowed segment are left unclaimed, so one DRAM location never has two addresses. The control inputs are captured on each clock edge. The decode itself is combinational from the CPU address and the captured controls.

Top module: `shadow_seg_decode`

## Requirements
- R1: While reset is asserted the captured controls are cleared whatever the control inputs carry. With cleared controls, a read anywhere in C0000h–FFFFFh asserts only `rom_cs`, and a write there asserts only `wr_inhibit`.
- R2: Segment n (n = 0..11) covers C0000h + n·4000h up to 16 KiB. Segment 12 covers F0000h–FFFFFh. Bit n of `shd_rd_dram` set makes reads in segment n assert `dram_cs` with `dram_addr` equal to the CPU address. Bit n clear makes them assert `rom_cs`.
- R3: Bit n of `shd_wr_en` set makes writes in segment n assert `dram_cs`. Bit n clear makes them assert `wr_inhibit` and no select. This holds independently of the read bit of the same segment.
- R4: Control inputs act on the decode from the first rising clock edge after they change, and not before.
- R5: Any read or write in A0000h–BFFFFh asserts `isa_cs` only, regardless of the shadow controls.
- R6: A read or write below A0000h, or at or above 100000h outside the relocation window, asserts `dram_cs` with `dram_addr` equal to the CPU address.
- R7: With `remap_en` set, an access at or above 100000h inside [`mem_top`·10000h, `mem_top`·10000h + 60000h) asserts `dram_cs`, and `dram_addr` is the CPU address minus `mem_top`·10000h plus A0000h. With `remap_en` clear the same address is decoded as in R6.
- R8: A relocation-window access whose translated address lies in a segment with either control bit set asserts no select. If it is a write, `wr_inhibit` is also asserted.
- R9: When `mem_rd` and `mem_wr` are both high or both low, no select and no inhibit is asserted.
- R10: At most one of `rom_cs`, `dram_cs`, `isa_cs` and `wr_inhibit` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for capturing the control inputs |
| rst_n | input | 1 | Active-low reset, clears the captured controls |
| cpu_addr | input | 24 | CPU byte address |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| shd_rd_dram | input | 13 | Per-segment read source: 1 = DRAM, 0 = ROM |
| shd_wr_en | input | 13 | Per-segment write enable for the DRAM copy |
| remap_en | input | 1 | Relocate the hidden 384 KiB to the memory top |
| mem_top | input | 8 | Installed memory top in 64 KiB units |
| rom_cs | output | 1 | Select for the ROM device |
| dram_cs | output | 1 | Select for DRAM |
| isa_cs | output | 1 | Select for the expansion bus (video hole) |
| wr_inhibit | output | 1 | Write discarded by shadow protection |
| dram_addr | output | 24 | Address presented to DRAM |

## Verification
The bench builds the decoder with its default 24-bit address, which makes the full 16 MiB range and every segment edge reachable. The vector table uses two installed-memory tops, 20h and 40h. Their relocation windows start at 2 MiB and 4 MiB, so both window edges can be tested. Translated addresses at the start, middle and end of the hidden area reach the video chunk, a 16 KiB window segment and the firmware segment. These are the cases needed to check the suppression rule.

// File: rtl/shadow_seg_decode.sv
module shadow_seg_decode #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic [12:0]       shd_rd_dram,
  input  logic [12:0]       shd_wr_en,
  input  logic              remap_en,
  input  logic [ADDR_W-17:0] mem_top,
  output logic              rom_cs,
  output logic              dram_cs,
  output logic              isa_cs,
  output logic              wr_inhibit,
  output logic [ADDR_W-1:0] dram_addr
);
  localparam int TOP_W = ADDR_W - 16;
  localparam logic [ADDR_W:0] VID_LO  = (ADDR_W+1)'(20'hA0000);
  localparam logic [ADDR_W:0] SHD_LO  = (ADDR_W+1)'(20'hC0000);
  localparam logic [ADDR_W:0] BIOS_LO = (ADDR_W+1)'(20'hF0000);
  localparam logic [ADDR_W:0] HI_LO   = (ADDR_W+1)'(24'h100000);
  localparam logic [ADDR_W:0] WIN_SZ  = (ADDR_W+1)'(20'h60000);

  logic [12:0]      rd_q, we_q;
  logic             remap_q;
  logic [TOP_W-1:0] top_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_q    <= '0;
      we_q    <= '0;
      remap_q <= 1'b0;
      top_q   <= '0;
    end else begin
      rd_q    <= shd_rd_dram;
      we_q    <= shd_wr_en;
      remap_q <= remap_en;
      top_q   <= mem_top;
    end

  function automatic logic [3:0] seg_of(input logic [ADDR_W:0] a);
    if (a >= BIOS_LO) return 4'd12;
    return 4'(a[19:14] - 6'd48);
  endfunction

  logic [ADDR_W:0]   a_x, base_x, phys_x;
  logic              acc_rd, acc_wr, acc_any;
  logic              in_vid, in_shd, in_win;
  logic [15:0]       rd_pad, we_pad;
  logic [3:0]        seg, pseg;
  logic              s_rd, s_we, win_used;

  assign a_x     = {1'b0, cpu_addr};
  assign base_x  = {1'b0, top_q, 16'h0000};
  assign phys_x  = a_x - base_x + VID_LO;
  assign acc_rd  = mem_rd & ~mem_wr;
  assign acc_wr  = mem_wr & ~mem_rd;
  assign acc_any = acc_rd | acc_wr;

  assign in_vid = (a_x >= VID_LO) && (a_x < SHD_LO);
  assign in_shd = (a_x >= SHD_LO) && (a_x < HI_LO);
  assign in_win = remap_q && (a_x >= HI_LO) && (a_x >= base_x) && (a_x < base_x + WIN_SZ);

  assign rd_pad   = {3'b000, rd_q};
  assign we_pad   = {3'b000, we_q};
  assign seg      = seg_of(a_x);
  assign pseg     = seg_of(phys_x);
  assign s_rd     = rd_pad[seg];
  assign s_we     = we_pad[seg];
  assign win_used = (phys_x >= SHD_LO) && (rd_pad[pseg] | we_pad[pseg]);

  assign rom_cs     = in_shd & acc_rd & ~s_rd;
  assign isa_cs     = in_vid & acc_any;
  assign wr_inhibit = acc_wr & ((in_shd & ~s_we) | (in_win & win_used));
  assign dram_addr  = in_win ? phys_x[ADDR_W-1:0] : cpu_addr;

  always_comb begin
    if (in_shd)      dram_cs = (acc_rd & s_rd) | (acc_wr & s_we);
    else if (in_win) dram_cs = acc_any & ~win_used;
    else if (in_vid) dram_cs = 1'b0;
    else             dram_cs = acc_any;
  end

  assert_one_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rom_cs, dram_cs, isa_cs, wr_inhibit}) <= 1);

  assert_rom_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rom_cs |-> (mem_rd && cpu_addr >= ADDR_W'(20'hC0000) && cpu_addr <= ADDR_W'(20'hFFFFF)));

  assert_isa_in_hole_R5: assert property (@(posedge clk) disable iff (!rst_n)
    isa_cs |-> (cpu_addr >= ADDR_W'(20'hA0000) && cpu_addr <= ADDR_W'(20'hBFFFF)));

  assert_inhibit_on_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_inhibit |-> (mem_wr && !mem_rd));

  assert_idle_strobes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd == mem_wr) |-> !(rom_cs || dram_cs || isa_cs || wr_inhibit));

  assert_translate_lands_hidden_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_addr != cpu_addr) |-> (dram_addr >= ADDR_W'(20'hA0000) && dram_addr <= ADDR_W'(20'hFFFFF)));

  assert_shadow_addr_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_cs && cpu_addr >= ADDR_W'(20'hC0000) && cpu_addr <= ADDR_W'(20'hFFFFF)) |-> (dram_addr == cpu_addr));
endmodule

// File: tb/shadow_seg_decode_tb_top.sv
module shadow_seg_decode_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] cpu_addr = '0;
  logic        mem_rd = 1'b0, mem_wr = 1'b0;
  logic [12:0] shd_rd_dram = '0, shd_wr_en = '0;
  logic        remap_en = 1'b0;
  logic [7:0]  mem_top = 8'h20;
  logic        rom_cs, dram_cs, isa_cs, wr_inhibit;
  logic [23:0] dram_addr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  shadow_seg_decode #(.ADDR_W(24)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .shd_rd_dram(shd_rd_dram), .shd_wr_en(shd_wr_en), .remap_en(remap_en), .mem_top(mem_top),
    .rom_cs(rom_cs), .dram_cs(dram_cs), .isa_cs(isa_cs), .wr_inhibit(wr_inhibit),
    .dram_addr(dram_addr));

  // {rd_dram, wr_en, remap, top, addr, {rd,wr}, {rom,dram,isa,inh}, exp_addr, req}
  localparam int NV = 25;
  localparam logic [92:0] VEC [NV] = '{
    {13'h0000,13'h0000,1'b0,8'h20,24'h0C0000,2'b10,4'b1000,24'h0C0000,4'd2},  // R2
    {13'h0001,13'h0000,1'b0,8'h20,24'h0C3FFF,2'b10,4'b0100,24'h0C3FFF,4'd2},  // R2
    {13'h0001,13'h0000,1'b0,8'h20,24'h0C4000,2'b10,4'b1000,24'h0C4000,4'd2},  // R2
    {13'h0000,13'h0002,1'b0,8'h20,24'h0C4000,2'b01,4'b0100,24'h0C4000,4'd3},  // R3
    {13'h0000,13'h0002,1'b0,8'h20,24'h0C4000,2'b10,4'b1000,24'h0C4000,4'd3},  // R3
    {13'h0002,13'h0000,1'b0,8'h20,24'h0C4000,2'b01,4'b0001,24'h0C4000,4'd3},  // R3
    {13'h1000,13'h0000,1'b0,8'h20,24'h0FFFF0,2'b10,4'b0100,24'h0FFFF0,4'd2},  // R2
    {13'h0800,13'h0000,1'b0,8'h20,24'h0EC000,2'b10,4'b0100,24'h0EC000,4'd2},  // R2
    {13'h0800,13'h0000,1'b0,8'h20,24'h0F0000,2'b10,4'b1000,24'h0F0000,4'd2},  // R2
    {13'h1FFF,13'h1FFF,1'b0,8'h20,24'h0A0000,2'b01,4'b0010,24'h0A0000,4'd5},  // R5
    {13'h1FFF,13'h1FFF,1'b0,8'h20,24'h0BFFFF,2'b10,4'b0010,24'h0BFFFF,4'd5},  // R5
    {13'h0000,13'h0000,1'b0,8'h20,24'h09FFFF,2'b10,4'b0100,24'h09FFFF,4'd6},  // R6
    {13'h0000,13'h0000,1'b1,8'h20,24'h200000,2'b10,4'b0100,24'h0A0000,4'd7},  // R7
    {13'h0000,13'h0000,1'b1,8'h20,24'h25FFFF,2'b01,4'b0100,24'h0FFFFF,4'd7},  // R7
    {13'h0000,13'h0000,1'b1,8'h20,24'h260000,2'b10,4'b0100,24'h260000,4'd6},  // R6
    {13'h0000,13'h0000,1'b0,8'h20,24'h200000,2'b10,4'b0100,24'h200000,4'd7},  // R7
    {13'h0000,13'h0000,1'b1,8'h40,24'h400000,2'b10,4'b0100,24'h0A0000,4'd7},  // R7
    {13'h0001,13'h0000,1'b1,8'h20,24'h220000,2'b01,4'b0001,24'h0C0000,4'd8},  // R8
    {13'h0000,13'h0001,1'b1,8'h20,24'h220000,2'b10,4'b0000,24'h0C0000,4'd8},  // R8
    {13'h0001,13'h0000,1'b1,8'h20,24'h224000,2'b10,4'b0100,24'h0C4000,4'd8},  // R8
    {13'h1000,13'h0000,1'b1,8'h20,24'h25C000,2'b10,4'b0000,24'h0FC000,4'd8},  // R8
    {13'h0000,13'h0000,1'b0,8'h20,24'h0C0000,2'b11,4'b0000,24'h0C0000,4'd9},  // R9
    {13'h0000,13'h0000,1'b0,8'h20,24'h100000,2'b00,4'b0000,24'h100000,4'd9},  // R9
    {13'h0000,13'h1000,1'b0,8'h20,24'h0F8000,2'b01,4'b0100,24'h0F8000,4'd3},  // R3
    {13'h1FFF,13'h1FFF,1'b0,8'h20,24'h0DFFFF,2'b01,4'b0100,24'h0DFFFF,4'd3}   // R3
  };

  task automatic chk(input string tag, input logic [27:0] act, input logic [27:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [27:0] outs();
    return {rom_cs, dram_cs, isa_cs, wr_inhibit, dram_addr};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    finish_run();
  end

  initial begin
    // R1: controls held clear in reset even with all-ones inputs
    shd_rd_dram = '1; shd_wr_en = '1;
    repeat (3) @(posedge clk);
    #2 cpu_addr = 24'h0C0000; mem_rd = 1'b1;
    #1 chk("R1 read", outs(), {4'b1000, 24'h0C0000});
    mem_rd = 1'b0; mem_wr = 1'b1; cpu_addr = 24'h0F0000;
    #1 chk("R1 write", outs(), {4'b0001, 24'h0F0000});
    mem_wr = 1'b0;
    @(negedge clk) rst_n = 1'b1; shd_rd_dram = '0; shd_wr_en = '0;
    @(posedge clk);
    // R4: control change acts only after the next rising edge
    @(negedge clk);
    cpu_addr = 24'h0C0000; mem_rd = 1'b1; shd_rd_dram = 13'h0001;
    #1 chk("R4 before edge", outs(), {4'b1000, 24'h0C0000});
    @(posedge clk);
    #1 chk("R4 after edge", outs(), {4'b0100, 24'h0C0000});
    mem_rd = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      mem_rd = 1'b0; mem_wr = 1'b0;
      {shd_rd_dram, shd_wr_en, remap_en, mem_top} = VEC[i][92:58];
      @(posedge clk);
      #2 {cpu_addr, mem_rd, mem_wr} = VEC[i][57:32];
      #1 chk($sformatf("R%0d vec %0d", VEC[i][3:0], i), outs(), VEC[i][31:4]);
      // R10: at most one target active
      chk("R10 onehot", 28'($countones({rom_cs, dram_cs, isa_cs, wr_inhibit}) <= 1), 28'd1);
    end
    finish_run();
  end
endmodule